// File: doc/BRIEF.md
# Five-Master Move-to-Back Bus Arbiter

This block decides which of five bus masters owns a shared bus. Master 0 is the local controller. Masters 1 to 4 are external devices. Each master has a request input and a grant output. A grant, once issued, stays in place until the owner signals the end of its transfer with a one-cycle done strobe. The arbiter then releases the bus for one cycle and arbitrates again.

Two ranking schemes are available, chosen by a single mode input. Fixed ranking always prefers the lowest-numbered master. Move-to-back ranking keeps an ordered list of master numbers. When a transfer finishes, its owner is pulled out of the list and appended at the tail. The masters behind it each move up one slot, so the others keep their relative order. The mode input is sampled only when a new grant is made. The list is retained while fixed ranking is in use, so move-to-back ranking later resumes from the order it had reached.

When the local controller acts as bus host, its request does not come from the external request pin. A host-enable input then selects an internal request line for master 0.

Top module: `arb_mtb_top`

## Requirements
- R1: While the asynchronous active-low reset is asserted, all grants are 0. After reset the priority list is 0,1,2,3,4 (slot 0 is highest).
- R2: The effective request of master 0 is `local_req_i` when `host_en_i`=1 and `req_ext_i[0]` when `host_en_i`=0. The unused source has no effect on the grants.
- R3: When no grant is held and some effective request is active with `mode_i`=0 (fixed), the next cycle grants the active requester with the lowest index.
- R4: When no grant is held and some effective request is active with `mode_i`=1 (move-to-back), the next cycle grants the active requester that stands earliest in the priority list.
- R5: When a transfer granted in move-to-back mode ends, the owner is removed from its slot and written into the last slot, and the entries behind it move up one slot. For example, owner 3 turns list 2,3,4,1,0 into 2,4,1,0,3.
- R6: The priority list changes only on the clock edge at which `xfer_done_i` is sampled high during a move-to-back grant. At every other edge it is unchanged.
- R7: `gnt_o` is one-hot or all-zero at all times, with bit i granting master i.
- R8: A grant stays unchanged while `xfer_done_i` is low. When done is sampled high the grant drops to zero on the next cycle, and arbitration resumes from that idle cycle.
- R9: With no effective request and no grant held, the grants stay zero and the list is unchanged.
- R10: A change of `mode_i` while a grant is held affects only the next arbitration. A transfer granted in fixed mode leaves the list untouched, so move-to-back ranking resumes from the retained order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_i | input | 1 | Ranking scheme: 0 fixed, 1 move-to-back |
| host_en_i | input | 1 | 1: master 0 requests through `local_req_i` |
| local_req_i | input | 1 | Internal request of the local controller |
| req_ext_i | input | 5 | External request pins, bit i for master i |
| xfer_done_i | input | 1 | One-cycle strobe: current owner has finished |
| gnt_o | output | 5 | One-hot grant, bit i for master i |

## Verification
The bench builds the arbiter with its default of five masters, which gives 3-bit list entries. Every ordering of the five-entry list can therefore be reached by long random runs of move-to-back grants. Directed sequences replay the documented list example and switch mode in mid-transfer. They also hold a grant across many cycles of changing requests and toggle the master-0 request source, so that the ignored pin is observed at the grant outputs.

// File: rtl/arb_mtb_pkg.sv
package arb_mtb_pkg;

  typedef enum logic {
    ARB_FIXED     = 1'b0,
    ARB_MOVE_BACK = 1'b1
  } arb_mode_e;

  typedef enum logic {
    OWN_IDLE = 1'b0,
    OWN_BUSY = 1'b1
  } own_state_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/arb_prio_list.sv
module arb_prio_list
  import arb_mtb_pkg::*;
#(
  parameter int unsigned N  = 5,
  parameter int unsigned IW = idx_width(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd_en,
  input  logic [IW-1:0]   mover,
  output logic [N*IW-1:0] list_o
);

  logic [IW-1:0] slot_q [N];
  logic [IW-1:0] slot_d [N];
  logic [N-1:0]  hit;
  logic [N-1:0]  passed;

  // hit marks the slot holding the mover; passed is set at and behind it
  for (genvar s = 0; s < N; s++) begin : g_match
    assign hit[s] = (slot_q[s] == mover);
    if (s == 0) begin : g_first
      assign passed[s] = hit[s];
    end else begin : g_rest
      assign passed[s] = passed[s-1] | hit[s];
    end
  end

  for (genvar s = 0; s < N; s++) begin : g_slot
    if (s == N-1) begin : g_tail
      always_comb begin
        slot_d[s] = slot_q[s];
        if (upd_en) slot_d[s] = mover;
      end
    end else begin : g_body
      always_comb begin
        slot_d[s] = slot_q[s];
        if (upd_en && passed[s]) slot_d[s] = slot_q[s+1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[s] <= IW'(s);
      end else if (upd_en) begin
        slot_q[s] <= slot_d[s];
      end
    end

    assign list_o[s*IW +: IW] = slot_q[s];
  end

endmodule

// File: rtl/arb_pick.sv
module arb_pick
  import arb_mtb_pkg::*;
#(
  parameter int unsigned N  = 5,
  parameter int unsigned IW = idx_width(N)
) (
  input  logic [N-1:0]    req,
  input  arb_mode_e       mode,
  input  logic [N*IW-1:0] list_i,
  output logic            valid,
  output logic [IW-1:0]   winner
);

  logic [IW-1:0] fixed_win;
  logic [IW-1:0] list_win;
  logic [IW-1:0] entry [N];

  for (genvar s = 0; s < N; s++) begin : g_unpack
    assign entry[s] = list_i[s*IW +: IW];
  end

  // scan from the back so the earliest match is the last assignment
  always_comb begin
    fixed_win = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (req[i]) fixed_win = IW'(i);
    end
  end

  always_comb begin
    list_win = entry[0];
    for (int s = N-1; s >= 0; s--) begin
      if (req[entry[s]]) list_win = entry[s];
    end
  end

  assign valid  = |req;
  assign winner = (mode == ARB_MOVE_BACK) ? list_win : fixed_win;

endmodule

// File: rtl/arb_mtb_top.sv
module arb_mtb_top
  import arb_mtb_pkg::*;
#(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_i,
  input  logic         host_en_i,
  input  logic         local_req_i,
  input  logic [N-1:0] req_ext_i,
  input  logic         xfer_done_i,
  output logic [N-1:0] gnt_o
);

  localparam int unsigned IW = idx_width(N);

  logic [N-1:0]    eff_req;
  logic [N*IW-1:0] list_w;
  logic            pick_valid;
  logic [IW-1:0]   pick_idx;

  own_state_e      state_q, state_d;
  logic [IW-1:0]   owner_q, owner_d;
  arb_mode_e       rot_q, rot_d;
  logic [N-1:0]    gnt_q, gnt_d;
  logic            list_upd;
  logic            ctl_en;

  // master 0 request source
  always_comb begin
    eff_req    = req_ext_i;
    eff_req[0] = host_en_i ? local_req_i : req_ext_i[0];
  end

  arb_pick #(.N(N), .IW(IW)) u_pick (
    .req    (eff_req),
    .mode   (arb_mode_e'(mode_i)),
    .list_i (list_w),
    .valid  (pick_valid),
    .winner (pick_idx)
  );

  arb_prio_list #(.N(N), .IW(IW)) u_list (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_en (list_upd),
    .mover  (owner_q),
    .list_o (list_w)
  );

  always_comb begin
    state_d  = state_q;
    owner_d  = owner_q;
    rot_d    = rot_q;
    gnt_d    = gnt_q;
    list_upd = 1'b0;
    ctl_en   = 1'b0;
    unique case (state_q)
      OWN_IDLE: begin
        if (pick_valid) begin
          ctl_en  = 1'b1;
          state_d = OWN_BUSY;
          owner_d = pick_idx;
          rot_d   = arb_mode_e'(mode_i);
          gnt_d   = N'(1) << pick_idx;
        end
      end
      OWN_BUSY: begin
        if (xfer_done_i) begin
          ctl_en   = 1'b1;
          state_d  = OWN_IDLE;
          gnt_d    = '0;
          list_upd = (rot_q == ARB_MOVE_BACK);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= OWN_IDLE;
      owner_q <= '0;
      rot_q   <= ARB_FIXED;
      gnt_q   <= '0;
    end else if (ctl_en) begin
      state_q <= state_d;
      owner_q <= owner_d;
      rot_q   <= rot_d;
      gnt_q   <= gnt_d;
    end
  end

  assign gnt_o = gnt_q;

endmodule

// File: rtl/arb_mtb_chk.sv
module arb_mtb_chk #(
  parameter int unsigned N  = 5,
  parameter int unsigned LW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_i,
  input logic          host_en_i,
  input logic          local_req_i,
  input logic [N-1:0]  req_ext_i,
  input logic          xfer_done_i,
  input logic [N-1:0]  gnt_o,
  input logic [LW-1:0] list_w
);

  logic [N-1:0] req_c;
  logic [N-1:0] low_c;

  always_comb begin
    req_c    = req_ext_i;
    req_c[0] = host_en_i ? local_req_i : req_ext_i[0];
    low_c    = req_c & (~req_c + 1'b1);
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o)); // R7

  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o != '0 && !xfer_done_i) |=> (gnt_o == $past(gnt_o))); // R8

  AST_GNT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o != '0 && xfer_done_i) |=> (gnt_o == '0)); // R8

  AST_GNT_TO_REQUESTER: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o == '0 && req_c != '0) |=> ((gnt_o & $past(req_c)) != '0)); // R4

  AST_FIXED_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o == '0 && req_c != '0 && !mode_i) |=> (gnt_o == $past(low_c))); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o == '0 && req_c == '0) |=> (gnt_o == '0 && $stable(list_w))); // R9

  AST_LIST_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(gnt_o != '0 && xfer_done_i) |=> $stable(list_w)); // R6

endmodule

bind arb_mtb_top arb_mtb_chk #(.N(N), .LW(N*IW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_i      (mode_i),
  .host_en_i   (host_en_i),
  .local_req_i (local_req_i),
  .req_ext_i   (req_ext_i),
  .xfer_done_i (xfer_done_i),
  .gnt_o       (gnt_o),
  .list_w      (list_w)
);

// File: tb/arb_mtb_top_tb.sv
module arb_mtb_top_tb_top;

  localparam int N = 5;

  logic         clk;
  logic         rst_n;
  logic         mode_i;
  logic         host_en_i;
  logic         local_req_i;
  logic [N-1:0] req_ext_i;
  logic         xfer_done_i;
  logic [N-1:0] gnt_o;

  int n_cmp;
  int n_bad;
  bit done_flag;

  // bench model
  int       m_list [N];
  bit       m_busy;
  bit       m_rot;
  int       m_own;
  logic [N-1:0] m_gnt;

  arb_mtb_top #(.N(N)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .host_en_i   (host_en_i),
    .local_req_i (local_req_i),
    .req_ext_i   (req_ext_i),
    .xfer_done_i (xfer_done_i),
    .gnt_o       (gnt_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [N-1:0] eff_of(logic h, logic l, logic [N-1:0] e);
    logic [N-1:0] r;
    r = e;
    r[0] = h ? l : e[0];
    return r;
  endfunction

  function automatic int fixed_pick(logic [N-1:0] r);
    for (int i = 0; i < N; i++) if (r[i]) return i;
    return -1;
  endfunction

  function automatic int list_pick(logic [N-1:0] r);
    for (int s = 0; s < N; s++) if (r[m_list[s]]) return m_list[s];
    return -1;
  endfunction

  task automatic move_back(int who);
    int p;
    p = 0;
    for (int s = 0; s < N; s++) if (m_list[s] == who) p = s;
    for (int s = p; s < N-1; s++) m_list[s] = m_list[s+1];
    m_list[N-1] = who;
  endtask

  task automatic model_reset();
    for (int s = 0; s < N; s++) m_list[s] = s;
    m_busy = 0; m_rot = 0; m_own = 0; m_gnt = '0;
  endtask

  task automatic check(string tag);
    n_cmp++;
    if (gnt_o !== m_gnt) begin
      n_bad++;
      $display("FAIL %s: gnt actual=%b expected=%b", tag, gnt_o, m_gnt);
    end
    n_cmp++;
    if ($countones(gnt_o) > 1) begin
      n_bad++;
      $display("FAIL R7: gnt actual=%b expected at most one bit", gnt_o);
    end
  endtask

  // compare at negedge, then drive inputs for the next posedge and advance model
  task automatic step(string tag, logic md, logic h, logic l,
                      logic [N-1:0] e, logic dn);
    logic [N-1:0] r;
    int w;
    @(negedge clk);
    check(tag);
    mode_i = md; host_en_i = h; local_req_i = l; req_ext_i = e; xfer_done_i = dn;
    r = eff_of(h, l, e);
    if (!m_busy) begin
      if (r != '0) begin
        w = md ? list_pick(r) : fixed_pick(r);
        m_busy = 1; m_own = w; m_rot = md; m_gnt = N'(1) << w;
      end
    end else if (dn) begin
      if (m_rot) move_back(m_own);
      m_busy = 0; m_gnt = '0;
    end
  endtask

  initial begin
    #2000000;
    if (!done_flag) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    n_cmp = 0; n_bad = 0; done_flag = 0;
    rst_n = 1'b0; mode_i = 0; host_en_i = 1; local_req_i = 1;
    req_ext_i = '1; xfer_done_i = 0;
    model_reset();
    // R1: grants stay low in reset even with requests present
    repeat (3) begin
      @(negedge clk);
      check("R1");
    end
    local_req_i = 0; req_ext_i = '0;
    rst_n = 1'b1;

    // R1/R3: all request in fixed mode, master 0 first
    step("R1", 0, 1, 1, 5'b11110, 0);
    step("R3", 0, 1, 1, 5'b11110, 0);
    step("R8", 0, 1, 1, 5'b11110, 1);
    step("R8", 0, 1, 0, 5'b11000, 0);
    step("R3", 0, 1, 0, 5'b11000, 0);
    step("R3", 0, 1, 0, 5'b00000, 1);
    // R2: host mode ignores ext pin 0
    step("R2", 0, 1, 0, 5'b00001, 0);
    step("R2", 0, 1, 0, 5'b00001, 0);
    step("R2", 0, 1, 0, 5'b00001, 0);
    // R2: non-host mode uses ext pin 0, ignores local request
    step("R2", 0, 0, 0, 5'b00001, 0);
    step("R2", 0, 0, 0, 5'b00001, 1);
    step("R2", 0, 0, 1, 5'b00000, 0);
    step("R2", 0, 0, 1, 5'b00000, 0);
    // R9: idle
    repeat (4) step("R9", 1, 1, 0, 5'b00000, 0);

    // R5 example: wins 1, 0, 3 give list 2,4,1,0,3
    step("R4", 1, 1, 0, 5'b00010, 0);
    step("R6", 1, 1, 0, 5'b00010, 0);
    step("R5", 1, 1, 0, 5'b00000, 1);
    step("R4", 1, 1, 1, 5'b00000, 0);
    step("R5", 1, 1, 0, 5'b00000, 1);
    step("R4", 1, 1, 0, 5'b01000, 0);
    step("R5", 1, 1, 0, 5'b00000, 1);
    step("R5", 1, 1, 1, 5'b11110, 0);   // expect master 2
    step("R5", 1, 1, 1, 5'b11110, 0);
    // R8: hold with changing requests and no done
    repeat (6) step("R8", 1, 1, 1, 5'($urandom), 0);
    // R10: mode flips to fixed mid-transfer, list keeps
    step("R10", 0, 1, 0, 5'b00000, 1);
    step("R10", 0, 1, 0, 5'b10010, 0);  // fixed: master 1
    step("R10", 1, 1, 0, 5'b00000, 1);  // fixed owner: list untouched
    step("R10", 1, 1, 1, 5'b11110, 0);  // move-to-back resumes
    step("R10", 1, 1, 1, 5'b11110, 1);
    step("R10", 1, 1, 1, 5'b11110, 0);

    // random traffic
    for (int k = 0; k < 4000; k++) begin
      logic md, h, l, dn;
      logic [N-1:0] e;
      md = (($urandom % 4) != 0);
      h  = (($urandom % 8) != 0);
      l  = 1'($urandom);
      e  = N'($urandom) & N'($urandom);
      dn = (($urandom % 3) == 0);
      step(m_rot ? "R5" : "R3", md, h, l, e, dn);
    end
    @(negedge clk);
    check("R4");

    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule